// File: doc/BRIEF.md
# Serial link error monitor

This block watches a synchronous serial shift engine and records four kinds of fault. A transmit underrun is a slave transfer that starts before software has refilled the transmit buffer. A receive overrun is a new frame that arrives before the last one was read. A phase fault is a data line that moves around a sampling edge. A baud fault is a slave shift clock that runs at less than half or more than twice its programmed rate. Each fault has its own enable and its own sticky flag. A flag stays set until a one is written to its clear strobe.

The engine drives the monitor with single-cycle strobes: buffer written, frame started, frame completed, buffer read, sampling edge and shift-clock edge. The engine also supplies the raw data-in level. Software sets the enables, the clear strobes, the reload value and the automatic-reset option. With that option on, a baud fault also sends a one-cycle reset request back to the engine.

Top module: `serr_monitor`

## Requirements
- R1: A fault whose enable bit is 0 never sets its flag. Vector bit positions are: bit 0 transmit underrun, bit 1 receive overrun, bit 2 phase, bit 3 baud. These apply to `err_en_i`, `err_clr_i` and `err_flag_o`.
- R2: In slave mode, `frame_start_i` sets flag bit 0 when `tbuf_wr_i` has not pulsed since the previous start. A write in the same cycle as the start counts as a refill. In master mode, a start never sets the flag.
- R3: `frame_done_i` sets flag bit 1 when an earlier completed frame has not been followed by `rbuf_rd_i`. A read in the same cycle as the new completion counts as reading the old word.
- R4: A sampling edge sets flag bit 2 when data-in one cycle before the strobe differs from data-in one cycle after it.
- R5: In slave mode, the interval is the number of clock cycles between two consecutive `sclk_edge_i` strobes. Flag bit 3 is set when that interval exceeds 4 x (reload + 1). The first edge after slave mode is entered only arms the check. In master mode, the check is off.
- R6: Flag bit 3 is also set when the interval is below reload + 1. Intervals from reload + 1 up to 4 x (reload + 1) inclusive set nothing.
- R7: With `auto_rst_en_i` at 1, an enabled baud fault pulses `eng_rst_o` for one cycle, together with the flag rising. With it at 0, `eng_rst_o` stays 0.
- R8: A 1 on a clear bit drops that flag on the next cycle. A 0 leaves it unchanged. Clearing one flag does not touch the others.
- R9: When a fault and its clear arrive in the same cycle, the flag ends up set.
- R10: Flags hold their value with no clear and no new fault.
- R11: After reset, all flags and `eng_rst_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| err_en_i | input | 4 | Per-fault enable |
| err_clr_i | input | 4 | Per-fault write-one clear strobes |
| auto_rst_en_i | input | 1 | Request engine reset on baud fault |
| slave_i | input | 1 | Engine is in slave mode |
| reload_i | input | RLD_W | Baud reload value |
| tbuf_wr_i | input | 1 | Transmit buffer written |
| frame_start_i | input | 1 | Transfer started |
| frame_done_i | input | 1 | Frame received |
| rbuf_rd_i | input | 1 | Receive buffer read |
| sample_edge_i | input | 1 | Sampling edge strobe |
| din_i | input | 1 | Serial data-in level |
| sclk_edge_i | input | 1 | Shift-clock edge strobe |
| err_flag_o | output | 4 | Sticky fault flags |
| eng_rst_o | output | 1 | One-cycle engine reset request |

## Verification
The underrun, overrun and baud flags, and the reset request, rise at the first clock edge after the strobe that causes them. The phase flag needs one more edge, because its comparison waits for the data-in value after the sampling edge. The bench drives every input just after a falling edge and steps one rising edge. It compares outputs at the next falling edge, and for the phase case it inserts the extra step before comparing. A cycle model of the underrun and overrun rules predicts each flag during a randomized run. Directed sequences place shift-clock intervals exactly on and just past both window limits.

// File: rtl/serr_pkg.sv
package serr_pkg;
  localparam int unsigned ERR_N = 4;

  typedef enum logic [1:0] {
    ERR_TX = 2'd0,
    ERR_RX = 2'd1,
    ERR_PH = 2'd2,
    ERR_BD = 2'd3
  } err_idx_e;

  typedef logic [ERR_N-1:0] err_vec_t;
endpackage

// File: rtl/serr_flag_bank.sv
module serr_flag_bank
  import serr_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  err_vec_t hit_i,
  input  err_vec_t en_i,
  input  err_vec_t clr_i,
  output err_vec_t flag_o
);

  for (genvar g = 0; g < ERR_N; g++) begin : g_flag
    logic q, d, upd;

    always_comb begin
      upd = (hit_i[g] & en_i[g]) | clr_i[g];
      d   = (hit_i[g] & en_i[g]) | (q & ~clr_i[g]);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  q <= 1'b0;
      else if (upd) q <= d;
    end

    assign flag_o[g] = q;

    assert_masked_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_i[g] && !q) |=> !q);
    assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[g] && !(hit_i[g] && en_i[g])) |=> !q);
    assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_i[g] && en_i[g]) |=> q);
    assert_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q && !clr_i[g]) |=> q);
  end

endmodule

// File: rtl/serr_xfer_chk.sv
module serr_xfer_chk (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slave_i,
  input  logic tbuf_wr_i,
  input  logic frame_start_i,
  input  logic frame_done_i,
  input  logic rbuf_rd_i,
  output logic tx_hit_o,
  output logic rx_hit_o
);

  logic fresh_q, fresh_d, fresh_en;
  logic unread_q, unread_d, unread_en;

  always_comb begin
    tx_hit_o  = slave_i & frame_start_i & ~(fresh_q | tbuf_wr_i);
    fresh_en  = frame_start_i | tbuf_wr_i;
    fresh_d   = ~frame_start_i;
    rx_hit_o  = frame_done_i & unread_q & ~rbuf_rd_i;
    unread_en = frame_done_i | rbuf_rd_i;
    unread_d  = frame_done_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fresh_q  <= 1'b0;
      unread_q <= 1'b0;
    end else begin
      if (fresh_en)  fresh_q  <= fresh_d;
      if (unread_en) unread_q <= unread_d;
    end
  end

  assert_refill_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tbuf_wr_i && !frame_start_i) |=> !tx_hit_o);
  assert_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rbuf_rd_i && !frame_done_i) |=> !rx_hit_o);

endmodule

// File: rtl/serr_phase_chk.sv
module serr_phase_chk (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_edge_i,
  input  logic din_i,
  output logic hit_o
);

  logic din_d1_q;
  logic before_q;
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      din_d1_q <= 1'b0;
      before_q <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      din_d1_q <= din_i;
      pend_q   <= sample_edge_i;
      if (sample_edge_i) before_q <= din_d1_q;
    end
  end

  assign hit_o = pend_q & (din_i ^ before_q);

  assert_pend_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_edge_i |=> pend_q);
  assert_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_edge_i |=> !hit_o);

endmodule

// File: rtl/serr_baud_chk.sv
module serr_baud_chk #(
  parameter int unsigned RLD_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slave_i,
  input  logic             sclk_edge_i,
  input  logic [RLD_W-1:0] reload_i,
  output logic             hit_o
);

  localparam int unsigned CNT_W = RLD_W + 3;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  logic [CNT_W-1:0] rld_ext, slow_lim;
  logic             too_slow, too_fast;

  always_comb begin
    rld_ext  = {3'b000, reload_i};
    slow_lim = (rld_ext + 1'b1) << 2;
    too_slow = (cnt_q >= slow_lim);
    too_fast = (cnt_q < rld_ext);
    hit_o    = slave_i & sclk_edge_i & armed_q & (too_slow | too_fast);
    armed_d  = slave_i & (armed_q | sclk_edge_i);
    if (!slave_i || sclk_edge_i) cnt_d = '0;
    else if (cnt_q == CNT_MAX)   cnt_d = cnt_q;
    else                         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assert_count_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slave_i && !sclk_edge_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_master_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slave_i |=> !armed_q);

endmodule

// File: rtl/serr_monitor.sv
module serr_monitor
  import serr_pkg::*;
#(
  parameter int unsigned RLD_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       err_en_i,
  input  logic [3:0]       err_clr_i,
  input  logic             auto_rst_en_i,
  input  logic             slave_i,
  input  logic [RLD_W-1:0] reload_i,
  input  logic             tbuf_wr_i,
  input  logic             frame_start_i,
  input  logic             frame_done_i,
  input  logic             rbuf_rd_i,
  input  logic             sample_edge_i,
  input  logic             din_i,
  input  logic             sclk_edge_i,
  output logic [3:0]       err_flag_o,
  output logic             eng_rst_o
);

  logic [1:0] rs_q;
  logic       rst_n;
  err_vec_t   hit;
  err_vec_t   flag;
  logic       tx_hit, rx_hit, ph_hit, bd_hit;
  logic       eng_rst_q, eng_rst_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  serr_xfer_chk i_xfer (
    .clk_i         (clk_i),
    .rst_ni        (rst_n),
    .slave_i       (slave_i),
    .tbuf_wr_i     (tbuf_wr_i),
    .frame_start_i (frame_start_i),
    .frame_done_i  (frame_done_i),
    .rbuf_rd_i     (rbuf_rd_i),
    .tx_hit_o      (tx_hit),
    .rx_hit_o      (rx_hit)
  );

  serr_phase_chk i_phase (
    .clk_i         (clk_i),
    .rst_ni        (rst_n),
    .sample_edge_i (sample_edge_i),
    .din_i         (din_i),
    .hit_o         (ph_hit)
  );

  serr_baud_chk #(.RLD_W(RLD_W)) i_baud (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .slave_i     (slave_i),
    .sclk_edge_i (sclk_edge_i),
    .reload_i    (reload_i),
    .hit_o       (bd_hit)
  );

  always_comb begin
    hit         = '0;
    hit[ERR_TX] = tx_hit;
    hit[ERR_RX] = rx_hit;
    hit[ERR_PH] = ph_hit;
    hit[ERR_BD] = bd_hit;
    eng_rst_d   = bd_hit & err_en_i[ERR_BD] & auto_rst_en_i;
  end

  serr_flag_bank i_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .hit_i  (hit),
    .en_i   (err_en_i),
    .clr_i  (err_clr_i),
    .flag_o (flag)
  );

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) eng_rst_q <= 1'b0;
    else        eng_rst_q <= eng_rst_d;
  end

  assign err_flag_o = flag;
  assign eng_rst_o  = eng_rst_q;

  assert_autorst_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    eng_rst_o |-> err_flag_o[ERR_BD]);
  assert_autorst_off_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    !auto_rst_en_i |=> !eng_rst_o);
  assert_reset_state_R11: assert property (@(posedge clk_i)
    !rst_n |-> (err_flag_o == '0 && !eng_rst_o));

endmodule

// File: tb/test_serr_monitor.sv
`timescale 1ns/1ps
module test_serr_monitor;
  localparam int unsigned RLD_W = 15;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [3:0]       en, clr;
  logic             auto_rst, slave;
  logic [RLD_W-1:0] reload;
  logic             wr, start, done, rd, samp, din, sclk;
  logic [3:0]       flags;
  logic             eng_rst;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  logic       m_fresh, m_unread;
  logic [3:0] m_flag;

  always #2 clk = ~clk;

  serr_monitor #(.RLD_W(RLD_W)) i_serr_monitor (
    .clk_i(clk), .rst_ni(rst_n), .err_en_i(en), .err_clr_i(clr),
    .auto_rst_en_i(auto_rst), .slave_i(slave), .reload_i(reload),
    .tbuf_wr_i(wr), .frame_start_i(start), .frame_done_i(done),
    .rbuf_rd_i(rd), .sample_edge_i(samp), .din_i(din), .sclk_edge_i(sclk),
    .err_flag_o(flags), .eng_rst_o(eng_rst)
  );

  function automatic logic [3:0] next_flags(logic [3:0] f, logic [3:0] hits,
                                            logic [3:0] e, logic [3:0] c);
    return (hits & e) | (f & ~c);
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    logic [3:0] h;
    @(posedge clk);
    h = '0;
    h[0] = start & slave & ~(m_fresh | wr);
    h[1] = done & m_unread & ~rd;
    m_flag = next_flags(m_flag, h, en, clr);
    if (start) m_fresh = 1'b0; else if (wr) m_fresh = 1'b1;
    if (done) m_unread = 1'b1; else if (rd) m_unread = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic edge_pulse();
    sclk = 1'b1; cyc(); sclk = 1'b0;
  endtask

  task automatic clear_all();
    clr = 4'hF; cyc(); clr = 4'h0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd1234);
    rst_n = 1'b0; en = 4'h0; clr = 4'h0; auto_rst = 1'b0; slave = 1'b1;
    reload = 15'd3; wr = 0; start = 0; done = 0; rd = 0; samp = 0; din = 0; sclk = 0;
    m_fresh = 0; m_unread = 0; m_flag = 0;
    repeat (3) @(negedge clk);
    chk("R11 flags in reset", flags, 0);
    chk("R11 eng_rst in reset", eng_rst, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 flags after reset", flags, 0);
    chk("R11 eng_rst after reset", eng_rst, 0);

    // R1: underrun and overrun with enables off
    start = 1; cyc(); start = 0;
    done = 1; cyc(); cyc(); done = 0;
    chk("R1 disabled faults", flags, 0);

    // R2: underrun in slave mode
    en = 4'hF;
    start = 1; cyc(); start = 0;
    chk("R2 start without refill", flags[0], 1);
    clear_all();
    chk("R8 clear after underrun", flags, 0);
    wr = 1; cyc(); wr = 0; idle(2);
    start = 1; cyc(); start = 0;
    chk("R2 refilled start", flags[0], 0);
    wr = 1; start = 1; cyc(); wr = 0; start = 0;
    chk("R2 write with start", flags[0], 0);
    slave = 0; start = 1; cyc(); start = 0; slave = 1;
    chk("R2 master no underrun", flags[0], 0);

    // R9: set and clear together
    start = 1; cyc(); start = 0;
    chk("R2 second underrun", flags[0], 1);
    start = 1; clr = 4'h1; cyc(); start = 0; clr = 4'h0;
    chk("R9 set wins", flags[0], 1);
    clr = 4'h2; cyc(); clr = 4'h0;
    chk("R8 other clear keeps", flags[0], 1);
    clr = 4'h0; idle(5);
    chk("R10 sticky", flags[0], 1);
    clr = 4'h1; cyc(); clr = 4'h0;
    chk("R8 clear tx", flags[0], 0);

    // R3: overrun (unread word pending from R1 run)
    rd = 1; cyc(); rd = 0;
    done = 1; cyc(); done = 0;
    chk("R3 single frame", flags[1], 0);
    done = 1; cyc(); done = 0;
    chk("R3 overrun", flags[1], 1);
    clear_all();
    rd = 1; done = 1; cyc(); rd = 0; done = 0;
    chk("R3 read with new frame", flags[1], 0);
    rd = 1; cyc(); rd = 0;
    done = 1; cyc(); done = 0;
    chk("R3 read then frame", flags[1], 0);

    // R4: phase check
    din = 0; idle(3);
    samp = 1; cyc(); samp = 0; cyc(); cyc();
    chk("R4 stable data", flags[2], 0);
    samp = 1; cyc(); samp = 0; din = 1; cyc(); cyc();
    chk("R4 change after edge", flags[2], 1);
    clear_all();
    din = 1; idle(3);
    din = 0; samp = 1; cyc(); samp = 0; cyc(); cyc();
    chk("R4 change at edge", flags[2], 1);
    clear_all();
    en = 4'hB; din = 0; idle(2);
    samp = 1; cyc(); samp = 0; din = 1; cyc(); cyc();
    chk("R1 phase disabled", flags[2], 0);
    en = 4'hF;

    // R5/R6: baud window, reload 3 -> limits 4..16
    clear_all();
    slave = 0; cyc(); slave = 1;
    edge_pulse();
    idle(7);  edge_pulse(); chk("R6 interval 8", flags[3], 0);
    idle(15); edge_pulse(); chk("R5 interval 16 edge", flags[3], 0);
    idle(3);  edge_pulse(); chk("R6 interval 4 edge", flags[3], 0);
    idle(16); edge_pulse();
    chk("R5 interval 17", flags[3], 1);
    chk("R7 no reset when off", eng_rst, 0);
    clr = 4'h8; cyc(); clr = 4'h0;
    chk("R8 clear baud", flags[3], 0);
    idle(1); edge_pulse();
    chk("R6 interval 3", flags[3], 1);

    // R7: auto reset
    clear_all();
    auto_rst = 1;
    slave = 0; cyc(); slave = 1;
    edge_pulse(); idle(40); edge_pulse();
    chk("R7 reset pulse", eng_rst, 1);
    chk("R7 flag with reset", flags[3], 1);
    cyc();
    chk("R7 reset one cycle", eng_rst, 0);
    chk("R10 baud sticky", flags[3], 1);
    auto_rst = 0;

    // R5: master mode ignores clock edges
    clear_all();
    slave = 0;
    edge_pulse(); edge_pulse(); idle(50); edge_pulse();
    chk("R5 master ignored", flags[3], 0);
    slave = 1;

    // Random run on underrun/overrun with model
    clear_all();
    wr = 1; start = 1; rd = 1; cyc(); wr = 0; start = 0; rd = 0;
    m_fresh = 0; m_unread = 0; m_flag = 0;
    chk("R8 random sync", flags, 0);
    for (int i = 0; i < 3000; i++) begin
      if (i % 64 == 0) en = 4'($urandom);
      wr    = ($urandom % 4) == 0;
      start = ($urandom % 5) == 0;
      done  = ($urandom % 5) == 0;
      rd    = ($urandom % 4) == 0;
      clr   = (($urandom % 8) == 0) ? 4'($urandom) : 4'h0;
      slave = ($urandom % 8) != 0;
      din   = 1'($urandom);
      cyc();
      chk("R1/R2/R3/R8/R9/R10 random", flags, m_flag);
      chk("R7 random no reset", eng_rst, 0);
    end
    wr = 0; start = 0; done = 0; rd = 0; clr = 0;

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule